// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block is a memory-mapped timer with a parameterised number of independent down-counting channels. A bus master programs each channel through three word registers: a control word, an interval (reload) value and a read-only view of the live count. Two shared words serve every channel: a per-channel interrupt enable mask, and a per-channel pending-flag word that is cleared by writing ones. A single interrupt line is raised whenever a channel that has its enable bit set also has a pending flag.

Every channel counts pulses of the shared `tick_in` input after they pass through its own power-of-two prescaler. It runs in periodic mode, where it reloads and goes on, or in one-shot mode, where it stops at zero. Each channel is built around a three-state machine. IDLE holds the count frozen. IDLE goes to RUN once the enable bit is set. RUN goes to DRAIN when software clears the enable bit. RUN goes straight back to IDLE when a one-shot expiry clears that bit in hardware. DRAIN keeps counting for two more prescaled ticks and then goes to IDLE. A DRAIN that meets a one-shot expiry also goes to IDLE at once. Software that reads the count and inverts it gets an up-counting view of time.

Top module: `tmr_top`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Word addressing is by byte offset. Offset 0x00 holds the interrupt enable mask, with bit n for channel n. Offset 0x04 holds the pending flags, with bit n for channel n. Channel n has its control word at 0x10*n+0x10, its interval at 0x10*n+0x14 (read/write) and its live count at 0x10*n+0x18 (read-only, so writes are dropped). Any other offset reads zero and ignores writes.
- R3: The control word has these fields. Bit 0 is enable. Bit 1 is reload request. Bits 3:2 are the source select, which is stored and read back. Bits 6:4 are the prescaler exponent P. Bit 7 is one-shot (1) or periodic (0). Bits above 7 read zero.
- R4: A reload request copies the interval into the count on the next prescaled tick and then clears itself.
- R5: A running channel's prescaler passes one tick out of every 2^P `tick_in` pulses. The count drops by one on each passed tick.
- R6: In periodic mode, a passed tick that finds the count at zero loads the interval, and the enable bit stays set.
- R7: In one-shot mode, the tick that brings the count to zero also clears the enable bit. The channel then stops, and further pulses leave the count at zero.
- R8: The tick that brings a count from one to zero sets that channel's pending flag. Writing a 1 to a flag bit clears it, writing a 0 leaves it, and a new expiry in the same cycle wins over the clear.
- R9: `irq` is high exactly when some channel has both its pending flag and its enable mask bit set.
- R10: After software clears the enable bit, the channel still counts two more prescaled ticks and then freezes.
- R11: With an interval of all ones in periodic mode, the channel is a free-running down-counter that wraps from zero to all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | Count-source pulse, one cycle per source tick |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, combinational, zero when no read is strobed |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench counts the exact number of ticks left after a disable. A design with no DRAIN state would freeze at once, and one that drained too long would count a third tick. It checks that a one-shot expiry clears the enable bit and stays at zero, where a design that fell through to periodic reload would read back the interval. It checks that the reload request clears itself, that the prescaler waits for 2^P pulses and not P pulses, that a write to the count word or an unmapped word has no effect, and that the interrupt line follows the enable mask and not the raw flags alone. A final reset in the middle of a run must bring every register back to zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } ch_state_t;

    // control word field positions (decoded by the channel)
    localparam int CTL_EN     = 0;
    localparam int CTL_RLD    = 1;
    localparam int CTL_SRC_LO = 2;
    localparam int SRC_W      = 2;
    localparam int CTL_PRE_LO = 4;
    localparam int PRE_W      = 3;
    localparam int CTL_ONE    = 7;
    localparam int CTL_W      = 8;

    // prescaled ticks still counted after a software disable
    localparam int DRAIN_TICKS = 2;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int EXP_W = PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             tick_in,
    input  logic [EXP_W-1:0] pres,
    output logic             ptick
);
    localparam int DIV_W = (1 << EXP_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask  = ~({DIV_W{1'b1}} << pres);
        ptick = active && tick_in && ((div_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            div_q <= '0;
        end else if (tick_in) begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_in,
    input  logic             ctrl_we,
    input  logic             intv_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CTL_W-1:0] ctrl_word,
    output logic [CNT_W-1:0] intv_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             hit
);
    localparam int DR_W = 2;

    ch_state_t        state_q, state_d;
    logic             en_q, rld_q, one_q;
    logic [SRC_W-1:0] src_q;
    logic [PRE_W-1:0] pres_q;
    logic [DR_W-1:0]  drain_q;
    logic             ptick, stop_hw, at_zero, active;

    assign active  = (state_q != ST_IDLE);
    assign at_zero = (cnt_q == '0);
    assign hit     = ptick && !rld_q && (cnt_q == CNT_W'(1));
    assign stop_hw = hit && one_q;

    tmr_prescaler #(.EXP_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .tick_in(tick_in),
        .pres   (pres_q),
        .ptick  (ptick)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (en_q) state_d = ST_RUN;
            ST_RUN: begin
                if (stop_hw)    state_d = ST_IDLE;
                else if (!en_q) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (stop_hw) state_d = ST_IDLE;
                else if (ptick && drain_q == DR_W'(DRAIN_TICKS - 1)) state_d = ST_IDLE;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath and control fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            rld_q   <= 1'b0;
            one_q   <= 1'b0;
            src_q   <= '0;
            pres_q  <= '0;
            intv_q  <= '0;
            cnt_q   <= '0;
            drain_q <= '0;
        end else begin
            if (ctrl_we) begin
                en_q   <= wdata[CTL_EN];
                rld_q  <= wdata[CTL_RLD];
                src_q  <= wdata[CTL_SRC_LO +: SRC_W];
                pres_q <= wdata[CTL_PRE_LO +: PRE_W];
                one_q  <= wdata[CTL_ONE];
            end else begin
                if (stop_hw)        en_q  <= 1'b0;
                if (ptick && rld_q) rld_q <= 1'b0;
            end
            if (intv_we) intv_q <= wdata;
            if (ptick) begin
                if (rld_q || at_zero) cnt_q <= intv_q;
                else                  cnt_q <= cnt_q - 1'b1;
            end
            if (state_q != ST_DRAIN) drain_q <= '0;
            else if (ptick)          drain_q <= drain_q + 1'b1;
        end
    end

    always_comb begin
        ctrl_word                          = '0;
        ctrl_word[CTL_EN]                  = en_q;
        ctrl_word[CTL_RLD]                 = rld_q;
        ctrl_word[CTL_SRC_LO +: SRC_W]     = src_q;
        ctrl_word[CTL_PRE_LO +: PRE_W]     = pres_q;
        ctrl_word[CTL_ONE]                 = one_q;
    end

    // R7: a frozen channel keeps its count
    assert_idle_count_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> $stable(cnt_q));

    // R4: the reload request clears itself once consumed
    assert_reload_selfclear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ptick && rld_q && !ctrl_we) |=> !rld_q);

    // R7: one-shot expiry stops the channel
    assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_hw && !ctrl_we) |=> (!en_q && state_q == ST_IDLE));

    // R10: drain never outlasts its tick budget
    assert_drain_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |-> (drain_q < DR_W'(DRAIN_TICKS)));
endmodule

// File: rtl/tmr_top.sv
module tmr_top
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam int SLOT_W = ADDR_W - 4;

    logic [NUM_CH-1:0] ien_q, stat_q, ch_hit, ctrl_we, intv_we;
    logic [CTL_W-1:0]  ch_ctrl [NUM_CH];
    logic [CNT_W-1:0]  ch_intv [NUM_CH];
    logic [CNT_W-1:0]  ch_cnt  [NUM_CH];
    logic [SLOT_W-1:0] slot;
    logic [1:0]        word;
    logic              aligned, wr, rd, glob;

    assign slot    = bus_addr[ADDR_W-1:4];
    assign word    = bus_addr[3:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr      = bus_valid && bus_write && aligned;
    assign rd      = bus_valid && !bus_write && aligned;
    assign glob    = (slot == '0);

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            assign ctrl_we[c] = wr && (slot == SLOT_W'(c + 1)) && (word == 2'd0);
            assign intv_we[c] = wr && (slot == SLOT_W'(c + 1)) && (word == 2'd1);

            tmr_channel #(.CNT_W(CNT_W)) u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick_in  (tick_in),
                .ctrl_we  (ctrl_we[c]),
                .intv_we  (intv_we[c]),
                .wdata    (bus_wdata),
                .ctrl_word(ch_ctrl[c]),
                .intv_q   (ch_intv[c]),
                .cnt_q    (ch_cnt[c]),
                .hit      (ch_hit[c])
            );

            always_ff @(posedge clk) begin
                if (!rst_n)                                    stat_q[c] <= 1'b0;
                else if (ch_hit[c])                            stat_q[c] <= 1'b1;
                else if (wr && glob && word == 2'd1 && bus_wdata[c]) stat_q[c] <= 1'b0;
            end

            // R8: write-one clears a flag when no expiry competes
            assert_flag_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (wr && glob && word == 2'd1 && bus_wdata[c] && !ch_hit[c]) |=> !stat_q[c]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)                          ien_q <= '0;
        else if (wr && glob && word == 2'd0) ien_q <= bus_wdata[NUM_CH-1:0];
    end

    assign irq = |(stat_q & ien_q);

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            if (glob) begin
                if (word == 2'd0)      bus_rdata = CNT_W'(ien_q);
                else if (word == 2'd1) bus_rdata = CNT_W'(stat_q);
            end else begin
                for (int k = 0; k < NUM_CH; k++) begin
                    if (slot == SLOT_W'(k + 1)) begin
                        unique case (word)
                            2'd0:    bus_rdata = CNT_W'(ch_ctrl[k]);
                            2'd1:    bus_rdata = ch_intv[k];
                            2'd2:    bus_rdata = ch_cnt[k];
                            default: bus_rdata = '0;
                        endcase
                    end
                end
            end
        end
    end

    // R9: an interrupt needs at least one enabled channel
    assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien_q != '0));
endmodule

// File: tb/sim_tmr_top.sv
module sim_tmr_top;
    localparam int NUM_CH = 2;
    localparam int CNT_W  = 32;
    localparam int ADDR_W = 8;
    localparam int NV     = 55;

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_IRQ = 2'd3;

    // {op, req, addr, data, expected}
    localparam logic [77:0] VEC [NV] = '{
        {OP_RD,  4'd1,  8'h00, 32'h0,        32'h0},        // R1 enable mask
        {OP_RD,  4'd1,  8'h04, 32'h0,        32'h0},        // R1 flags
        {OP_RD,  4'd1,  8'h10, 32'h0,        32'h0},        // R1 control
        {OP_RD,  4'd1,  8'h18, 32'h0,        32'h0},        // R1 count
        {OP_IRQ, 4'd1,  8'h00, 32'h0,        32'h0},        // R1 irq low
        {OP_WR,  4'd2,  8'h14, 32'd5,        32'h0},        // R2 interval
        {OP_RD,  4'd2,  8'h14, 32'h0,        32'd5},
        {OP_WR,  4'd4,  8'h10, 32'h03,       32'h0},        // R4 en + reload
        {OP_TK,  4'd4,  8'h00, 32'd1,        32'h0},
        {OP_RD,  4'd4,  8'h10, 32'h0,        32'h01},       // R4 reload cleared
        {OP_RD,  4'd4,  8'h18, 32'h0,        32'd5},        // R4 loaded
        {OP_TK,  4'd5,  8'h00, 32'd3,        32'h0},
        {OP_RD,  4'd5,  8'h18, 32'h0,        32'd2},        // R5 decrement
        {OP_TK,  4'd8,  8'h00, 32'd2,        32'h0},
        {OP_RD,  4'd8,  8'h04, 32'h0,        32'h1},        // R8 flag set
        {OP_RD,  4'd5,  8'h18, 32'h0,        32'd0},
        {OP_TK,  4'd6,  8'h00, 32'd1,        32'h0},
        {OP_RD,  4'd6,  8'h18, 32'h0,        32'd5},        // R6 periodic reload
        {OP_RD,  4'd6,  8'h10, 32'h0,        32'h01},       // R6 still enabled
        {OP_WR,  4'd8,  8'h04, 32'h1,        32'h0},
        {OP_RD,  4'd8,  8'h04, 32'h0,        32'h0},        // R8 write-one clear
        {OP_WR,  4'd2,  8'h18, 32'h1234,     32'h0},
        {OP_RD,  4'd2,  8'h18, 32'h0,        32'd5},        // R2 count read-only
        {OP_WR,  4'd2,  8'h0C, 32'hFFFFFFFF, 32'h0},
        {OP_RD,  4'd2,  8'h0C, 32'h0,        32'h0},        // R2 unmapped
        {OP_RD,  4'd2,  8'h1C, 32'h0,        32'h0},
        {OP_RD,  4'd2,  8'h38, 32'h0,        32'h0},
        {OP_WR,  4'd10, 8'h10, 32'h0,        32'h0},        // R10 disable
        {OP_TK,  4'd10, 8'h00, 32'd1,        32'h0},
        {OP_RD,  4'd10, 8'h18, 32'h0,        32'd4},        // R10 still counting
        {OP_TK,  4'd10, 8'h00, 32'd2,        32'h0},
        {OP_RD,  4'd10, 8'h18, 32'h0,        32'd3},        // R10 frozen after two
        {OP_WR,  4'd7,  8'h24, 32'd3,        32'h0},
        {OP_WR,  4'd7,  8'h20, 32'h93,       32'h0},        // R7 one-shot, P=1
        {OP_TK,  4'd5,  8'h00, 32'd2,        32'h0},
        {OP_RD,  4'd5,  8'h28, 32'h0,        32'd3},        // R5 /2 prescale
        {OP_TK,  4'd5,  8'h00, 32'd2,        32'h0},
        {OP_RD,  4'd5,  8'h28, 32'h0,        32'd2},
        {OP_TK,  4'd7,  8'h00, 32'd4,        32'h0},
        {OP_RD,  4'd7,  8'h20, 32'h0,        32'h90},       // R7 enable cleared
        {OP_RD,  4'd8,  8'h04, 32'h0,        32'h2},        // R8 channel 1 flag
        {OP_TK,  4'd7,  8'h00, 32'd4,        32'h0},
        {OP_RD,  4'd7,  8'h28, 32'h0,        32'd0},        // R7 stays stopped
        {OP_WR,  4'd9,  8'h00, 32'h2,        32'h0},
        {OP_IRQ, 4'd9,  8'h00, 32'h0,        32'h1},        // R9 irq raised
        {OP_WR,  4'd9,  8'h00, 32'h1,        32'h0},
        {OP_IRQ, 4'd9,  8'h00, 32'h0,        32'h0},        // R9 masked
        {OP_WR,  4'd3,  8'h20, 32'h04,       32'h0},
        {OP_RD,  4'd3,  8'h20, 32'h0,        32'h04},       // R3 source field
        {OP_WR,  4'd11, 8'h14, 32'hFFFFFFFF, 32'h0},
        {OP_WR,  4'd11, 8'h10, 32'h03,       32'h0},
        {OP_TK,  4'd11, 8'h00, 32'd2,        32'h0},
        {OP_RD,  4'd11, 8'h18, 32'h0,        32'hFFFFFFFE}, // R11 free-running
        {OP_WR,  4'd8,  8'h04, 32'h2,        32'h0},
        {OP_RD,  4'd8,  8'h04, 32'h0,        32'h0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_in = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [CNT_W-1:0]  bus_wdata = '0;
    logic [CNT_W-1:0]  bus_rdata;
    logic              irq;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    tmr_top #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_read(input int req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        n_vec++;
        if (bus_rdata !== exp) begin
            n_bad++;
            $display("FAIL R%0d read 0x%02h: got 0x%08h expected 0x%08h", req, a, bus_rdata, exp);
        end
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_in = 1'b1;
            @(negedge clk); tick_in = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic chk_irq(input int req, input logic exp);
        @(negedge clk);
        n_vec++;
        if (irq !== exp) begin
            n_bad++;
            $display("FAIL R%0d irq: got %0b expected %0b", req, irq, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int v = 0; v < NV; v++) begin
            logic [1:0]  op;
            int          rq;
            logic [7:0]  ad;
            logic [31:0] dt, ex;
            op = VEC[v][77:76];
            rq = int'(VEC[v][75:72]);
            ad = VEC[v][71:64];
            dt = VEC[v][63:32];
            ex = VEC[v][31:0];
            unique case (op)
                OP_WR:   do_write(ad, dt);
                OP_RD:   do_read(rq, ad, ex);
                OP_TK:   do_ticks(int'(dt));
                default: chk_irq(rq, ex[0]);
            endcase
        end
        // directed: R1 reset in the middle of a run, with a flag pending
        do_write(8'h00, 32'h1);
        do_write(8'h14, 32'd1);
        do_write(8'h10, 32'h03);
        do_ticks(2);
        chk_irq(9, 1'b1);                     // R9 channel 0 expired, enabled
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_read(1, 8'h18, 32'h0);             // R1 count cleared
        do_read(1, 8'h10, 32'h0);             // R1 control cleared
        do_read(1, 8'h00, 32'h0);             // R1 mask cleared
        do_read(1, 8'h04, 32'h0);             // R1 flags cleared
        chk_irq(1, 1'b0);
        // directed: R5 prescale /8 needs eight pulses per count
        do_write(8'h14, 32'd9);
        do_write(8'h10, 32'h33);
        do_ticks(8);
        do_read(5, 8'h18, 32'd9);
        do_ticks(7);
        do_read(5, 8'h18, 32'd9);
        do_ticks(1);
        do_read(5, 8'h18, 32'd8);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule